// File: doc/BRIEF.md
# Scrambled NRZI Serial Video Transmitter

This block turns a stream of 10-bit component video words into a single serial bit stream for a coaxial link. It takes one word per word period, which is ten bit periods, and sends that word's bits one at a time, least significant bit first. Each serial bit then goes through a self-synchronizing scrambler with generator x^9 + x^4 + 1, and after that through an NRZI line coder. The scrambler breaks up long runs and repeating patterns. The NRZI coder turns the remaining runs of ones into line transitions.

The block runs on one clock and uses a bit-rate clock enable (`bit_en`). Each enabled cycle is one serial bit period. A four-bit position counter splits the bit periods into word periods of exactly ten bits. A new word is taken on the enabled cycle that sends the last bit of the current word. Words leave in the order they arrive, so the multiplexed chroma/luma sequence (CB, Y, CR, Y, ...) is kept. In 8-bit mode only the eight upper bits of the word carry data.

Top module: `vid_serial_tx`

## Requirements
- R1: A synchronous reset clears the line output `ser_out` to 0 and clears the scrambler history to all zeros. The bit position is set so that the first enabled cycle after reset takes a word and sends one filler 0 bit before that word's bits.
- R2: A word is taken on every tenth enabled cycle, so exactly ten serial bits are sent per word. Words are sent in arrival order.
- R3: Each word is sent least significant bit first: bit 0 on the enabled cycle after the word is taken, and bit 9 on the enabled cycle that takes the next word.
- R4: The scrambled bit is s = d XOR h4 XOR h9. Here d is the data bit and hk is the scrambled bit sent k bit periods earlier (taken as 0 before reset history exists).
- R5: On each enabled cycle, `ser_out` toggles when the scrambled bit is 1 and holds when it is 0.
- R6: If `word_vld` is low on a word-taking cycle, an all-zero word is sent in that slot.
- R7: If `mode_8b` is high on a word-taking cycle, the two least significant bits sent for that word are 0 and bits 9..2 come from `word_in[9:2]`.
- R8: On a cycle with `bit_en` low, `ser_out`, the bit position and the scrambler history do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One serial bit period per high cycle |
| word_in | input | 10 | Parallel video word |
| word_vld | input | 1 | Word valid, sampled on word-taking cycles |
| mode_8b | input | 1 | 8-bit mode: two LSBs sent as zero |
| ser_out | output | 1 | NRZI-coded serial line bit |

## Verification
The hardest cases to reach are the scrambler's history states, because they depend on the last nine sent bits rather than on the current word. Examples are the cleared history with all-zero data, which gives a line with no transitions, and an all-ones stream that drives the history through its long cycle. Directed runs of blank words and of all-ones words set up these histories. The random phase adds gaps in `bit_en`, invalid words and 8-bit mode switches at arbitrary bit positions, so word-taking cycles fall next to stalls. Every enabled bit is compared with a bench-side reference stream.

// File: rtl/vst_pkg.sv
package vst_pkg;
   localparam int DEF_WORD_W   = 10;
   localparam int DEF_NARROW_W = 8;
   localparam int DEF_SCR_LEN  = 9;
   localparam int DEF_SCR_TAP  = 4;
endpackage

// File: rtl/vst_shifter.sv
module vst_shifter #(
   parameter int WORD_W   = vst_pkg::DEF_WORD_W,
   parameter int NARROW_W = vst_pkg::DEF_NARROW_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_en,
   input  logic [WORD_W-1:0] word_in,
   input  logic              word_vld,
   input  logic              narrow,
   output logic              nrz_bit
);
   localparam int PH_W = $clog2(WORD_W);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(WORD_W - 1);
   localparam int PAD_W = WORD_W - NARROW_W;

   if (WORD_W < 2) begin : g_bad_width
      $error("vst_shifter: WORD_W must be at least 2");
   end
   if (NARROW_W > WORD_W || NARROW_W < 1) begin : g_bad_narrow
      $error("vst_shifter: NARROW_W must be 1..WORD_W");
   end

   logic [PH_W-1:0]   phase;
   logic [WORD_W-1:0] sreg;
   logic [WORD_W-1:0] fill;
   logic              take;

   assign take = bit_en && (phase == PH_LAST);

   if (PAD_W > 0) begin : g_narrow
      always_comb begin
         if (!word_vld)   fill = '0;
         else if (narrow) fill = {word_in[WORD_W-1:PAD_W], {PAD_W{1'b0}}};
         else             fill = word_in;
      end
   end else begin : g_full
      always_comb fill = word_vld ? word_in : '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_LAST;
         sreg  <= '0;
      end else if (bit_en) begin
         if (phase == PH_LAST) begin
            phase <= '0;
            sreg  <= fill;
         end else begin
            phase <= phase + 1'b1;
            sreg  <= {1'b0, sreg[WORD_W-1:1]};
         end
      end
   end

   assign nrz_bit = sreg[0];

   // R2
   phase_range_chk: assert property (@(posedge clk) disable iff (rst)
      phase <= PH_LAST);
   // R2
   phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      take |=> phase == '0);
   // R8
   shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !bit_en |=> $stable(sreg) && $stable(phase));
   // R6
   blank_load_chk: assert property (@(posedge clk) disable iff (rst)
      take && !word_vld |=> sreg == '0);
   // R7
   narrow_load_chk: assert property (@(posedge clk) disable iff (rst)
      take && word_vld && narrow |=> sreg[0] == 1'b0);
endmodule

// File: rtl/vst_scrambler.sv
module vst_scrambler #(
   parameter int LEN = vst_pkg::DEF_SCR_LEN,
   parameter int TAP = vst_pkg::DEF_SCR_TAP
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic din,
   output logic dout
);
   if (TAP < 1 || TAP >= LEN) begin : g_bad_tap
      $error("vst_scrambler: TAP must be in 1..LEN-1");
   end

   logic [LEN-1:0] hist;

   assign dout = din ^ hist[TAP-1] ^ hist[LEN-1];

   always_ff @(posedge clk) begin
      if (rst)         hist <= '0;
      else if (bit_en) hist <= {hist[LEN-2:0], dout};
   end

   // R8
   scr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !bit_en |=> $stable(hist));
endmodule

// File: rtl/vst_nrzi.sv
module vst_nrzi (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic din,
   output logic line
);
   always_ff @(posedge clk) begin
      if (rst)         line <= 1'b0;
      else if (bit_en) line <= line ^ din;
   end
endmodule

// File: rtl/vid_serial_tx.sv
module vid_serial_tx #(
   parameter int WORD_W   = vst_pkg::DEF_WORD_W,
   parameter int NARROW_W = vst_pkg::DEF_NARROW_W,
   parameter int SCR_LEN  = vst_pkg::DEF_SCR_LEN,
   parameter int SCR_TAP  = vst_pkg::DEF_SCR_TAP
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_en,
   input  logic [WORD_W-1:0] word_in,
   input  logic              word_vld,
   input  logic              mode_8b,
   output logic              ser_out
);
   logic nrz_bit;
   logic scr_bit;

   vst_shifter #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_shift (
      .clk(clk), .rst(rst), .bit_en(bit_en), .word_in(word_in),
      .word_vld(word_vld), .narrow(mode_8b), .nrz_bit(nrz_bit));

   vst_scrambler #(.LEN(SCR_LEN), .TAP(SCR_TAP)) u_scr (
      .clk(clk), .rst(rst), .bit_en(bit_en), .din(nrz_bit), .dout(scr_bit));

   vst_nrzi u_nrzi (
      .clk(clk), .rst(rst), .bit_en(bit_en), .din(scr_bit), .line(ser_out));

   // R5
   line_toggle_chk: assert property (@(posedge clk) disable iff (rst)
      bit_en && scr_bit |=> ser_out != $past(ser_out));
   // R5
   line_hold_chk: assert property (@(posedge clk) disable iff (rst)
      bit_en && !scr_bit |=> ser_out == $past(ser_out));
   // R8
   line_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !bit_en |=> $stable(ser_out));
endmodule

// File: tb/vid_serial_tx_bench.sv
module vid_serial_tx_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bit_en = 1'b0;
   logic [9:0] word_in = '0;
   logic       word_vld = 1'b0;
   logic       mode_8b = 1'b0;
   logic       ser_out;

   int n_chk = 0;
   int n_pass = 0;
   bit done = 1'b0;

   int       m_phase;
   logic [9:0] m_bits;
   logic [8:0] m_hist;
   logic       m_lvl;

   always #4 clk = ~clk;

   vid_serial_tx u_vid_serial_tx (
      .clk(clk), .rst(rst), .bit_en(bit_en), .word_in(word_in),
      .word_vld(word_vld), .mode_8b(mode_8b), .ser_out(ser_out));

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act === exp) n_pass++;
      else $display("FAIL %s: ser_out=%b expected=%b", req, act, exp);
   endtask

   function automatic logic [9:0] fill_of(input logic [9:0] w, input logic v, input logic m8);
      if (!v)  return 10'h000;
      if (m8)  return {w[9:2], 2'b00};
      return w;
   endfunction

   task automatic model_reset();
      m_phase = 9; m_bits = '0; m_hist = '0; m_lvl = 1'b0;
   endtask

   task automatic model_step();
      logic d, s;
      d = m_bits[0];
      s = d ^ m_hist[3] ^ m_hist[8];
      m_hist = {m_hist[7:0], s};
      m_lvl = m_lvl ^ s;
      if (m_phase == 9) begin
         m_bits = fill_of(word_in, word_vld, mode_8b);
         m_phase = 0;
      end else begin
         m_bits = {1'b0, m_bits[9:1]};
         m_phase++;
      end
   endtask

   // called at a falling edge; checks at the next falling edge
   task automatic step(input string req, input logic en, input logic [9:0] w,
                       input logic v, input logic m8);
      bit_en = en; word_in = w; word_vld = v; mode_8b = m8;
      if (en) model_step();
      @(posedge clk); @(negedge clk);
      check(en ? req : "R8", ser_out, m_lvl);
   endtask

   task automatic do_reset();
      rst = 1'b1; bit_en = 1'b0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      model_reset();
      check("R1", ser_out, 1'b0);
      rst = 1'b0;
   endtask

   task automatic send_word(input string req, input logic [9:0] w,
                            input logic v, input logic m8);
      for (int i = 0; i < 10; i++) step(req, 1'b1, w, v, m8);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_pass, n_chk);
         $finish;
      end
   endtask

   initial begin
      #1200000;
      n_chk++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      logic [9:0] lvl_before;
      void'($urandom(32'h5eed_0259));
      @(negedge clk);
      do_reset();
      // R1 first bit after reset is filler; blank stream with cleared scrambler stays flat (R4, R6)
      for (int k = 0; k < 4; k++) send_word("R6", 10'h3FF, 1'b0, 1'b0);
      check("R6", ser_out, 1'b0);
      // all-ones words: scrambler history walks its long cycle (R4)
      for (int k = 0; k < 6; k++) send_word("R4", 10'h3FF, 1'b1, 1'b0);
      // single-bit words: bit order on the line (R3)
      send_word("R3", 10'h001, 1'b1, 1'b0);
      send_word("R3", 10'h200, 1'b1, 1'b0);
      // chroma/luma sequence keeps order (R2)
      send_word("R2", 10'h200, 1'b1, 1'b0);
      send_word("R2", 10'h040, 1'b1, 1'b0);
      send_word("R2", 10'h1C0, 1'b1, 1'b0);
      send_word("R2", 10'h3AC, 1'b1, 1'b0);
      // 8-bit mode drops the low bits (R7)
      send_word("R7", 10'h003, 1'b1, 1'b1);
      send_word("R7", 10'h3FF, 1'b1, 1'b1);
      // long stall: nothing moves (R8)
      lvl_before = {9'b0, ser_out};
      for (int k = 0; k < 25; k++) step("R8", 1'b0, 10'h155, 1'b1, 1'b0);
      check("R8", ser_out, lvl_before[0]);
      send_word("R5", 10'h2AA, 1'b1, 1'b0);
      // reset in mid-word restarts from the cleared state (R1)
      for (int k = 0; k < 4; k++) step("R5", 1'b1, 10'h155, 1'b1, 1'b0);
      do_reset();
      send_word("R1", 10'h000, 1'b1, 1'b0);
      check("R1", ser_out, 1'b0);
      send_word("R1", 10'h155, 1'b1, 1'b0);
      // constrained random
      for (int k = 0; k < 6000; k++) begin
         step("R5", ($urandom_range(0, 3) != 0), 10'($urandom_range(0, 1023)),
              ($urandom_range(0, 9) != 0), ($urandom_range(0, 4) == 0));
      end
      finish_run();
   end
endmodule